// File: doc/BRIEF.md
# CAM Filter Host Control Registers

A small bank of host-visible registers for a network address filter that sits in front of a chain of external content-addressable memories. It produces the active-low reset line for the whole CAM chain and lets the host gate two external events, an increment request and a CAM-full indication. After every destination-address lookup it holds on to the returned associated data so that the host can read it. It also keeps an 8-bit purge timestamp that the host cannot write directly but can advance through a separate strobe address.

The host uses a simple synchronous bus: a 3-bit address, a write enable with 16-bit write data, and a read enable. Read data is registered: it shows the addressed register in the cycle after `regRdEn`, and it holds its value while no read is requested. The address map is: 0 configuration, 1 target, 2 to 5 data words 0 to 3, 6 purge timestamp (read-only), and 7 purge-increment strobe. Writes take effect on the clock edge that samples `regWrEn`.

Top module: `camHostRegs`

## Requirements
- R1: Bit 0 of the configuration register (address 0) drives `camResetN` directly: 0 drives it low and 1 drives it high. All 16 configuration bits read back as written.
- R2: `camResetN` is low while `rstN` is low. It stays low after reset is released until the host writes the configuration register with bit 0 set.
- R3: `incrPulse` follows `incrIn` only when target bits [3:2] equal 11. The codes 00, 01 and 10 hold it at 0. All target bits read back as written.
- R4: `fullIrq` follows `camFullIn` only when target bits [1:0] equal 10. The codes 00, 01 and 11 hold it at 0.
- R5: On a cycle with `lookupDone` high, data word 0 (address 2) is loaded with `lookupData`. Bit 15 holds the permanent flag, bit 14 is forced to 0, bits [13:8] hold the port ID and bits [7:0] hold the timestamp.
- R6: When a host write to data word 0 and `lookupDone` occur in the same cycle, data word 0 takes the lookup data.
- R7: The purge timestamp (address 6) reads 0x0001 after reset, and its upper 8 bits read as 0. Host writes to address 6 have no effect.
- R8: Every write to address 7 adds one to the purge timestamp, whatever data is written. The count wraps from 0xFF to 0x00.
- R9: Data words 1 to 3 (addresses 3 to 5) and data word 0 read back what the host wrote. All data words reset to 0. `regRdData` updates only in the cycle after a read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regAddr | input | 3 | Register address |
| regWrEn | input | 1 | Write enable |
| regRdEn | input | 1 | Read enable |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Registered read data |
| lookupDone | input | 1 | Destination-address lookup finished this cycle |
| lookupData | input | 16 | Associated data returned by the lookup |
| incrIn | input | 1 | External increment request |
| camFullIn | input | 1 | CAM chain full indication |
| camResetN | output | 1 | Active-low reset to the CAM chain |
| incrPulse | output | 1 | Increment request after gating |
| fullIrq | output | 1 | CAM-full interrupt after gating |

## Verification
The bench builds the block with its default parameters: an 8-bit timestamp that resets to 0x01 and four data words. With these defaults the wrap from 0xFF to 0x00 is reached after 255 strobe writes, and every address in the 3-bit map, including the read-only and strobe addresses, can be read back. The bench walks through all four codes of each gating field, so that the reserved codes are exercised as well as the enabling code.

// File: rtl/camRegPkg.sv
package camRegPkg;
  localparam int DATA_W   = 16;
  localparam int ADDR_W   = 3;
  localparam int WORD_CNT = 4;
  localparam int IDX_W    = $clog2(WORD_CNT);

  localparam logic [ADDR_W-1:0] ADR_CFG   = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_TGT   = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_WORD0 = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_PURGE = 3'd6;
  localparam logic [ADDR_W-1:0] ADR_PINC  = 3'd7;

  localparam logic [1:0] INCR_ON = 2'b11;
  localparam logic [1:0] FULL_ON = 2'b10;

  typedef struct packed {
    logic                wrCfg;
    logic                wrTgt;
    logic [WORD_CNT-1:0] wrWord;
    logic                capture;
    logic                incPurge;
    logic                rdEn;
  } strobeT;
endpackage

// File: rtl/camRegCtrl.sv
module camRegCtrl
  import camRegPkg::*;
(
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic              lookupDone,
  output strobeT            stb
);
  always_comb begin
    stb          = '0;
    stb.wrCfg    = regWrEn && (regAddr == ADR_CFG);
    stb.wrTgt    = regWrEn && (regAddr == ADR_TGT);
    stb.incPurge = regWrEn && (regAddr == ADR_PINC);
    stb.capture  = lookupDone;
    stb.rdEn     = regRdEn;
    for (int k = 0; k < WORD_CNT; k++) begin
      stb.wrWord[k] = regWrEn && (regAddr == ADR_WORD0 + ADDR_W'(k));
    end
    // lookup capture takes priority over a host write to word 0
    if (lookupDone) stb.wrWord[0] = 1'b0;
  end
endmodule

// File: rtl/camRegData.sv
module camRegData
  import camRegPkg::*;
#(
  parameter int              TS_W     = 8,
  parameter logic [TS_W-1:0] TS_RESET = 8'h01
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            stb,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [DATA_W-1:0] lookupData,
  input  logic              incrIn,
  input  logic              camFullIn,
  output logic [DATA_W-1:0] regRdData,
  output logic              camResetN,
  output logic              incrPulse,
  output logic              fullIrq
);
  localparam int PAD_W = DATA_W - TS_W;

  logic [DATA_W-1:0] cfgQ, tgtQ;
  logic [DATA_W-1:0] wordQ [WORD_CNT];
  logic [TS_W-1:0]   tsQ;
  logic [DATA_W-1:0] captured, rdMux;
  logic [ADDR_W-1:0] wordIdx;

  assign captured = {lookupData[15], 1'b0, lookupData[13:0]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ <= '0;
      tgtQ <= '0;
      tsQ  <= TS_RESET;
    end else begin
      if (stb.wrCfg)    cfgQ <= regWrData;
      if (stb.wrTgt)    tgtQ <= regWrData;
      if (stb.incPurge) tsQ  <= tsQ + 1'b1;
    end
  end

  for (genvar k = 0; k < WORD_CNT; k++) begin : gWord
    if (k == 0) begin : gCap
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)               wordQ[k] <= '0;
        else if (stb.capture)    wordQ[k] <= captured;
        else if (stb.wrWord[k])  wordQ[k] <= regWrData;
      end
    end else begin : gPlain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)               wordQ[k] <= '0;
        else if (stb.wrWord[k])  wordQ[k] <= regWrData;
      end
    end
  end

  assign wordIdx = regAddr - ADR_WORD0;

  always_comb begin
    rdMux = '0;
    if (regAddr == ADR_CFG)        rdMux = cfgQ;
    else if (regAddr == ADR_TGT)   rdMux = tgtQ;
    else if (regAddr == ADR_PURGE) rdMux = {{PAD_W{1'b0}}, tsQ};
    else if (regAddr >= ADR_WORD0 && int'(wordIdx) < WORD_CNT)
      rdMux = wordQ[wordIdx[IDX_W-1:0]];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         regRdData <= '0;
    else if (stb.rdEn) regRdData <= rdMux;
  end

  assign camResetN = cfgQ[0];
  assign incrPulse = incrIn && (tgtQ[3:2] == INCR_ON);
  assign fullIrq   = camFullIn && (tgtQ[1:0] == FULL_ON);
endmodule

// File: rtl/camHostRegs.sv
module camHostRegs
  import camRegPkg::*;
#(
  parameter int              TS_W     = 8,
  parameter logic [TS_W-1:0] TS_RESET = 8'h01
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  regAddr,
  input  logic        regWrEn,
  input  logic        regRdEn,
  input  logic [15:0] regWrData,
  output logic [15:0] regRdData,
  input  logic        lookupDone,
  input  logic [15:0] lookupData,
  input  logic        incrIn,
  input  logic        camFullIn,
  output logic        camResetN,
  output logic        incrPulse,
  output logic        fullIrq
);
  strobeT stb;

  camRegCtrl i_ctrl (
    .regAddr(regAddr), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .lookupDone(lookupDone), .stb(stb)
  );

  camRegData #(.TS_W(TS_W), .TS_RESET(TS_RESET)) i_data (
    .clk(clk), .rstN(rstN), .stb(stb), .regAddr(regAddr),
    .regWrData(regWrData), .lookupData(lookupData),
    .incrIn(incrIn), .camFullIn(camFullIn), .regRdData(regRdData),
    .camResetN(camResetN), .incrPulse(incrPulse), .fullIrq(fullIrq)
  );
endmodule

// File: rtl/camHostRegsChk.sv
module camHostRegsChk (
  input logic        clk,
  input logic        rstN,
  input logic [2:0]  regAddr,
  input logic        regWrEn,
  input logic        regRdEn,
  input logic [15:0] regWrData,
  input logic [15:0] regRdData,
  input logic        incrIn,
  input logic        camFullIn,
  input logic        camResetN,
  input logic        incrPulse,
  input logic        fullIrq
);
  assert_cfg_drive_R1: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 3'd0) |=> (camResetN == $past(regWrData[0])));

  assert_hold_low_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!camResetN && !(regWrEn && regAddr == 3'd0 && regWrData[0])) |=> !camResetN);

  assert_incr_gate_R3: assert property (@(posedge clk) disable iff (!rstN)
    incrPulse |-> incrIn);

  assert_irq_gate_R4: assert property (@(posedge clk) disable iff (!rstN)
    fullIrq |-> camFullIn);

  assert_ts_upper_R7: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr == 3'd6) |=> (regRdData[15:8] == 8'h00));

  assert_rd_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !regRdEn |=> $stable(regRdData));
endmodule

bind camHostRegs camHostRegsChk u_chk (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
  .regRdEn(regRdEn), .regWrData(regWrData), .regRdData(regRdData),
  .incrIn(incrIn), .camFullIn(camFullIn), .camResetN(camResetN),
  .incrPulse(incrPulse), .fullIrq(fullIrq)
);

// File: tb/test_camHostRegs.sv
module test_camHostRegs;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  regAddr = '0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0;
  logic [15:0] regWrData = '0, regRdData;
  logic        lookupDone = 1'b0;
  logic [15:0] lookupData = '0;
  logic        incrIn = 1'b0, camFullIn = 1'b0;
  logic        camResetN, incrPulse, fullIrq;

  int errors = 0, checks = 0;
  logic rdFlag = 1'b0;
  logic [15:0] expQ [$];
  string       tagQ [$];

  always #5 clk = ~clk;

  camHostRegs i_camHostRegs (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regRdEn(regRdEn), .regWrData(regWrData), .regRdData(regRdData),
    .lookupDone(lookupDone), .lookupData(lookupData), .incrIn(incrIn),
    .camFullIn(camFullIn), .camResetN(camResetN), .incrPulse(incrPulse),
    .fullIrq(fullIrq)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: pops one expected item per completed read
  always @(posedge clk) rdFlag <= regRdEn;
  always @(negedge clk) begin
    if (rdFlag && expQ.size() > 0) check(tagQ.pop_front(), regRdData, expQ.pop_front());
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [15:0] exp, input string tag);
    @(negedge clk);
    regAddr = a; regRdEn = 1'b1;
    expQ.push_back(exp); tagQ.push_back(tag);
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    #2;
    check("R2 reset camResetN", {15'd0, camResetN}, 16'd0);
    check("R3 reset incrPulse", {15'd0, incrPulse}, 16'd0);
    check("R4 reset fullIrq", {15'd0, fullIrq}, 16'd0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    check("R2 low after release", {15'd0, camResetN}, 16'd0);
    rd(3'd6, 16'h0001, "R7 purge reset");
    rd(3'd2, 16'h0000, "R9 word0 reset");

    wr(3'd0, 16'hA5A4);
    check("R2 bit0 clear keeps low", {15'd0, camResetN}, 16'd0);
    rd(3'd0, 16'hA5A4, "R1 cfg readback");
    wr(3'd0, 16'h0001);
    check("R1 camResetN high", {15'd0, camResetN}, 16'd1);
    wr(3'd0, 16'h0000);
    check("R1 camResetN low", {15'd0, camResetN}, 16'd0);
    wr(3'd0, 16'h8001);

    for (int c = 0; c < 4; c++) begin
      wr(3'd1, 16'(c << 2));
      incrIn = 1'b1; #1;
      check("R3 incr gate", {15'd0, incrPulse}, {15'd0, c == 3});
      incrIn = 1'b0; #1;
      check("R3 incr low", {15'd0, incrPulse}, 16'd0);
      wr(3'd1, 16'(c));
      camFullIn = 1'b1; #1;
      check("R4 irq gate", {15'd0, fullIrq}, {15'd0, c == 2});
      camFullIn = 1'b0; #1;
      check("R4 irq low", {15'd0, fullIrq}, 16'd0);
    end
    wr(3'd1, 16'hFFF6);
    rd(3'd1, 16'hFFF6, "R3 tgt readback");

    @(negedge clk);
    lookupData = 16'hC5A3; lookupDone = 1'b1;
    @(negedge clk);
    lookupDone = 1'b0;
    rd(3'd2, 16'h85A3, "R5 capture");

    @(negedge clk);
    regAddr = 3'd2; regWrData = 16'h1234; regWrEn = 1'b1;
    lookupData = 16'h4077; lookupDone = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; lookupDone = 1'b0;
    rd(3'd2, 16'h0077, "R6 capture wins");

    wr(3'd2, 16'hBEEF);
    rd(3'd2, 16'hBEEF, "R9 word0 host");
    wr(3'd3, 16'h1111); wr(3'd4, 16'h2222); wr(3'd5, 16'h3333);
    rd(3'd3, 16'h1111, "R9 word1");
    rd(3'd4, 16'h2222, "R9 word2");
    rd(3'd5, 16'h3333, "R9 word3");

    wr(3'd6, 16'h00FF);
    rd(3'd6, 16'h0001, "R7 write ignored");
    wr(3'd7, 16'hFFFF);
    rd(3'd6, 16'h0002, "R8 increment");
    for (int i = 0; i < 253; i++) wr(3'd7, 16'(i));
    rd(3'd6, 16'h00FF, "R8 reach FF");
    wr(3'd7, 16'h0000);
    rd(3'd6, 16'h0000, "R8 wrap");
    repeat (3) @(negedge clk);
    check("R9 rd hold", regRdData, 16'h0000);
    finishRun();
  end
endmodule